// File: doc/BRIEF.md
# Split-Word 64-bit Sigma Unit

This unit serves a 32-bit processor that must compute the four sigma functions of the SHA-512 compression function on 64-bit words held as two 32-bit registers. Each issue takes two source operands, `rs1` and `rs2`, plus a three-bit operation code. It returns one 32-bit half of the chosen 64-bit result one clock later, together with a one-cycle valid flag. A full 64-bit sigma therefore costs two issues.

The two "big" sigmas (Σ0, Σ1) are built only from rotations. Their upper half comes from the low-half operation issued with the operands exchanged, so they have only a low-half code each. The two "small" sigmas (σ0, σ1) contain a plain right shift, which is not symmetric under an exchange. They therefore have separate low-half and high-half codes. In both high-half codes `rs1` carries the upper half of the word and `rs2` the lower half, so the rotation datapath is shared. Codes outside the six defined ones return zero.

Top module: `split_sigma_unit`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `outValid` is 0 and `outResult` is 0.
- R2: `outValid` is 1 in exactly the cycle after a cycle in which `inStrobe` was 1. Otherwise it is 0.
- R3: Code 0 (`3'd0`) returns bits [31:0] of Σ0(x) = ROTR28(x)^ROTR34(x)^ROTR39(x), with x = {rs2, rs1}.
- R4: Code 1 (`3'd1`) returns bits [31:0] of Σ1(x) = ROTR14(x)^ROTR18(x)^ROTR41(x), with x = {rs2, rs1}.
- R5: Issuing code 0 or code 1 with rs1 = upper half and rs2 = lower half of x returns bits [63:32] of Σ0(x) or Σ1(x).
- R6: Code 2 returns bits [31:0] of σ0(x) = ROTR1(x)^ROTR8(x)^SHR7(x), with x = {rs2, rs1}.
- R7: Code 3 returns bits [63:32] of σ0(x), with x = {rs1, rs2}.
- R8: Code 4 returns bits [31:0] of σ1(x) = ROTR19(x)^ROTR61(x)^SHR6(x), with x = {rs2, rs1}.
- R9: Code 5 returns bits [63:32] of σ1(x), with x = {rs1, rs2}.
- R10: Codes 6 and 7 return a result of zero, with `outValid` asserted as for any other strobe.
- R11: In a cycle where `inStrobe` is 0, changes on `opSel`, `rs1` and `rs2` leave `outResult` unchanged on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inStrobe | input | 1 | Issue an operation this cycle |
| opSel | input | 3 | Operation code (0..5 defined) |
| rs1 | input | 32 | First source operand |
| rs2 | input | 32 | Second source operand |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| outResult | output | 32 | Registered 32-bit half of the sigma result |

## Verification
The hardest case to reach from the ports is the bits that cross between the halves. These are the bits of the 64-bit rotations and shifts that move from `rs2` into the result and back, including the shift spill that must vanish only in the high-half small-sigma codes. Single-bit operands sit at each half's edge: bit 0 of one half, bit 31 of the other. They are run through every code, together with dense patterns, so that each crossing term lights a distinct result bit. The expected values come from full 64-bit rotations and are then split. The operand-swap issues then confirm that the same path yields the upper halves of the big sigmas.

// File: rtl/split_sigma_pkg.sv
package split_sigma_pkg;

  localparam int WORD_W = 32;
  localparam int OP_W   = 3;

  // Function family selected by the decoder
  typedef enum logic [1:0] {
    FN_BIG0 = 2'd0,
    FN_BIG1 = 2'd1,
    FN_SML0 = 2'd2,
    FN_SML1 = 2'd3
  } sigmaFn_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;      // capture a new result
    logic     legal;     // code is one of the six defined ones
    sigmaFn_e fn;        // which sigma
    logic     upperHalf; // small sigma: shift term without spill
  } dpCtrl_t;

  // Rotation / shift amounts on the 64-bit word
  localparam int B0_R1 = 28, B0_R2 = 34, B0_R3 = 39;
  localparam int B1_R1 = 14, B1_R2 = 18, B1_R3 = 41;
  localparam int S0_R1 = 1,  S0_R2 = 8,  S0_SH = 7;
  localparam int S1_R1 = 19, S1_R2 = 61, S1_SH = 6;

endpackage

// File: rtl/split_sigma_ctrl.sv
module split_sigma_ctrl
  import split_sigma_pkg::*;
#(
  parameter int OP_BITS = OP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inStrobe,
  input  logic [OP_BITS-1:0] opSel,
  output dpCtrl_t            dpCtrl,
  output logic               outValid
);

  localparam logic [OP_BITS-1:0] LAST_CODE = OP_BITS'(5);

  logic validQ;

  always_comb begin
    dpCtrl           = '0;
    dpCtrl.load      = inStrobe;
    dpCtrl.legal     = (opSel <= LAST_CODE);
    unique case (opSel[2:0])
      3'd0:    dpCtrl.fn = FN_BIG0;
      3'd1:    dpCtrl.fn = FN_BIG1;
      3'd2:    dpCtrl.fn = FN_SML0;
      3'd3: begin
        dpCtrl.fn        = FN_SML0;
        dpCtrl.upperHalf = 1'b1;
      end
      3'd4:    dpCtrl.fn = FN_SML1;
      3'd5: begin
        dpCtrl.fn        = FN_SML1;
        dpCtrl.upperHalf = 1'b1;
      end
      default: dpCtrl.fn = FN_BIG0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inStrobe;
  end

  assign outValid = validQ;

  // R2: valid follows a strobe by one cycle
  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |=> outValid);

  // R2: no valid without a strobe
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> !outValid);

endmodule

// File: rtl/split_sigma_dp.sv
module split_sigma_dp
  import split_sigma_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] rs1,
  input  logic [DATA_W-1:0] rs2,
  output logic [DATA_W-1:0] outResult
);

  localparam int DBL_W = 2 * DATA_W;

  // Lower half of ROTR(n) applied to {upr, lwr}
  function automatic logic [DATA_W-1:0] rotLow(
    input logic [DATA_W-1:0] lwr,
    input logic [DATA_W-1:0] upr,
    input int                n
  );
    if (n < DATA_W)
      return (lwr >> n) | (upr << (DATA_W - n));
    else
      return (upr >> (n - DATA_W)) | (lwr << (DBL_W - n));
  endfunction

  // Lower half of SHR(n) applied to {upr, lwr}, n < DATA_W
  function automatic logic [DATA_W-1:0] shrLow(
    input logic [DATA_W-1:0] lwr,
    input logic [DATA_W-1:0] upr,
    input int                n
  );
    return (lwr >> n) | (upr << (DATA_W - n));
  endfunction

  logic [DATA_W-1:0] big0Word, big1Word, sml0Word, sml1Word;
  logic [DATA_W-1:0] sml0Shift, sml1Shift;
  logic [DATA_W-1:0] resultNext, resultQ;

  // rs1 plays the "lower" role in every code; for the upper-half codes
  // the caller has already placed the upper half of the word in rs1.
  always_comb begin
    big0Word = rotLow(rs1, rs2, B0_R1) ^ rotLow(rs1, rs2, B0_R2) ^ rotLow(rs1, rs2, B0_R3);
    big1Word = rotLow(rs1, rs2, B1_R1) ^ rotLow(rs1, rs2, B1_R2) ^ rotLow(rs1, rs2, B1_R3);

    sml0Shift = dpCtrl.upperHalf ? (rs1 >> S0_SH) : shrLow(rs1, rs2, S0_SH);
    sml1Shift = dpCtrl.upperHalf ? (rs1 >> S1_SH) : shrLow(rs1, rs2, S1_SH);

    sml0Word = rotLow(rs1, rs2, S0_R1) ^ rotLow(rs1, rs2, S0_R2) ^ sml0Shift;
    sml1Word = rotLow(rs1, rs2, S1_R1) ^ rotLow(rs1, rs2, S1_R2) ^ sml1Shift;
  end

  always_comb begin
    if (!dpCtrl.legal) begin
      resultNext = '0;
    end else begin
      unique case (dpCtrl.fn)
        FN_BIG0: resultNext = big0Word;
        FN_BIG1: resultNext = big1Word;
        FN_SML0: resultNext = sml0Word;
        FN_SML1: resultNext = sml1Word;
        default: resultNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             resultQ <= '0;
    else if (dpCtrl.load)  resultQ <= resultNext;
  end

  assign outResult = resultQ;

  // R11: idle cycles leave the result untouched
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.load |=> $stable(outResult));

  // R10: undefined codes return zero
  a_r10_undefined_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.load && !dpCtrl.legal) |=> (outResult == '0));

  // R3: with both operands zero every code yields zero
  a_r3_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.load && rs1 == '0 && rs2 == '0) |=> (outResult == '0));

endmodule

// File: rtl/split_sigma_unit.sv
module split_sigma_unit
  import split_sigma_pkg::*;
#(
  parameter int DATA_W  = WORD_W,
  parameter int OP_BITS = OP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inStrobe,
  input  logic [OP_BITS-1:0] opSel,
  input  logic [DATA_W-1:0]  rs1,
  input  logic [DATA_W-1:0]  rs2,
  output logic               outValid,
  output logic [DATA_W-1:0]  outResult
);

  dpCtrl_t dpCtrl;

  split_sigma_ctrl #(.OP_BITS(OP_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inStrobe (inStrobe),
    .opSel    (opSel),
    .dpCtrl   (dpCtrl),
    .outValid (outValid)
  );

  split_sigma_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .rs1       (rs1),
    .rs2       (rs2),
    .outResult (outResult)
  );

endmodule

// File: tb/split_sigma_unit_tb.sv
`timescale 1ns/1ps
module split_sigma_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inStrobe = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] rs1 = '0;
  logic [31:0] rs2 = '0;
  logic        outValid;
  logic [31:0] outResult;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  split_sigma_unit u_dut (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .opSel(opSel),
    .rs1(rs1), .rs2(rs2), .outValid(outValid), .outResult(outResult)
  );

  // 64-bit reference functions
  function automatic logic [63:0] ror64(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction
  function automatic logic [63:0] refBig0(input logic [63:0] x);
    return ror64(x, 28) ^ ror64(x, 34) ^ ror64(x, 39);
  endfunction
  function automatic logic [63:0] refBig1(input logic [63:0] x);
    return ror64(x, 14) ^ ror64(x, 18) ^ ror64(x, 41);
  endfunction
  function automatic logic [63:0] refSml0(input logic [63:0] x);
    return ror64(x, 1) ^ ror64(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] refSml1(input logic [63:0] x);
    return ror64(x, 19) ^ ror64(x, 61) ^ (x >> 6);
  endfunction

  // Stimulus table: {a, b}; the 64-bit word is {b, a}
  localparam int NVEC = 8;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h00000000_00000000,
    64'hffffffff_ffffffff,
    64'h00000001_00000000,
    64'h00000000_80000000,
    64'h80000000_00000001,
    64'h01234567_89abcdef,
    64'hdeadbeef_0badf00d,
    64'hffffffff_00000000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one operation, check valid and result one cycle later
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    inStrobe = 1'b1; opSel = op; rs1 = a; rs2 = b;
    @(negedge clk);
    check({tag, " valid (R2)"}, {31'd0, outValid}, 32'd1);
    check(tag, outResult, exp);
    inStrobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, outValid}, 32'd0);
    check("R1 result in reset", outResult, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, outValid}, 32'd0);
    check("R1 result after reset", outResult, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] lo, hi;
      lo = VEC[i][63:32];
      hi = VEC[i][31:0];
      issue(3'd0, lo, hi, refBig0({hi, lo})[31:0], "R3 big0 low");
      issue(3'd1, lo, hi, refBig1({hi, lo})[31:0], "R4 big1 low");
      issue(3'd0, hi, lo, refBig0({hi, lo})[63:32], "R5 big0 high by swap");
      issue(3'd1, hi, lo, refBig1({hi, lo})[63:32], "R5 big1 high by swap");
      issue(3'd2, lo, hi, refSml0({hi, lo})[31:0], "R6 sml0 low");
      issue(3'd3, hi, lo, refSml0({hi, lo})[63:32], "R7 sml0 high");
      issue(3'd4, lo, hi, refSml1({hi, lo})[31:0], "R8 sml1 low");
      issue(3'd5, hi, lo, refSml1({hi, lo})[63:32], "R9 sml1 high");
    end

    // R10: undefined codes
    issue(3'd6, 32'hdeadbeef, 32'h12345678, 32'd0, "R10 code 6");
    issue(3'd7, 32'hffffffff, 32'hffffffff, 32'd0, "R10 code 7");

    // R11 / R2: idle cycles hold the result, valid drops
    issue(3'd2, 32'h89abcdef, 32'h01234567, refSml0(64'h01234567_89abcdef)[31:0], "R11 setup");
    opSel = 3'd4; rs1 = 32'h55555555; rs2 = 32'haaaaaaaa;
    @(negedge clk);
    check("R2 valid idle", {31'd0, outValid}, 32'd0);
    check("R11 hold", outResult, refSml0(64'h01234567_89abcdef)[31:0]);
    opSel = 3'd0; rs1 = 32'h1; rs2 = 32'h0;
    @(negedge clk);
    check("R11 hold second idle", outResult, refSml0(64'h01234567_89abcdef)[31:0]);

    // Back-to-back strobes (R2)
    @(negedge clk);
    inStrobe = 1'b1; opSel = 3'd4; rs1 = 32'h00000001; rs2 = 32'h0;
    @(negedge clk);
    check("R8 back-to-back first", outResult, refSml1(64'h00000000_00000001)[31:0]);
    opSel = 3'd5; rs1 = 32'h0; rs2 = 32'h80000000;
    @(negedge clk);
    check("R2 back-to-back valid", {31'd0, outValid}, 32'd1);
    check("R9 back-to-back second", outResult, refSml1(64'h00000000_80000000)[63:32]);
    inStrobe = 1'b0;

    // R1: reset in mid-run clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset valid", {31'd0, outValid}, 32'd0);
    check("R1 mid-run reset result", outResult, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule